// File: doc/BRIEF.md
# Random Number Generator Control Register Block

This block is the software-facing side of a random number generator peripheral. A 32-bit register bus (address, write strobe, write data, read strobe, read data) reaches six word-aligned registers: an identity word, a command word made of self-clearing action bits, a control word, a status word, an error code, and a read port that pops one generated word per access from a small output queue.

Software starts a self-test or a seed generation by writing a command bit. Each operation lasts a programmable number of cycles and then sets a done flag. The outcome of the statistical checks is not computed here. Two test inputs, sampled on the completing cycle, decide whether the operation ends cleanly. A seed attempt that fails leaves the generator unseeded and can be retried. Once a seed succeeds, the queue is filled at one word per cycle from a stand-in pseudo-random source. When automatic reseeding is enabled, a fresh seed is taken after a parameterised number of words have been served.

The interrupt line combines the done flags and the error flag, each with its own mask. The two clear commands behave differently: clearing the interrupt does nothing while an error code is held, and clearing the error removes both the error code and the done flags.

Top module: `rng_regblock`

## Requirements
- R1: Offset 0x00 reads the identity word: type code (1 = B variant, 2 = C variant) in bits 31:28, bits 27:16 zero, major revision in bits 15:8, minor revision in bits 7:0, all set by parameters.
- R2: Offset 0x04 is the command word. A written bit 0 starts a self-test and a written bit 1 starts a seed generation. Bit 0 wins when both are set. A start is ignored while an operation is in progress. Reads of this word always return zero.
- R3: Offset 0x08 is the control word: bit 4 enables automatic reseeding, bit 5 masks the done interrupt, bit 6 masks the error interrupt. All other bits read zero. The reset value is 0x60.
- R4: Status bit 4 (self-test done) sets exactly ST_CYCLES clock edges after the edge that accepts the start. If the self-test fail input is high on the completing edge, the error code becomes 0x1.
- R5: Status bit 5 (seed done) sets exactly SEED_CYCLES edges after the accepting edge. If the statistical fail input is high on the completing edge, the error code becomes 0x8 and the generator is left unseeded. Otherwise the generator is seeded.
- R6: Command bit 4 clears both done flags only while the error code is zero. Command bit 5 zeroes the error code and both done flags.
- R7: Offset 0x10 reads the error code. Status bit 16 is high exactly when the error code is non-zero. The status word at offset 0x0C has zero in all bits other than 16, 11:8, 5 and 4.
- R8: The interrupt output is high when (a done flag is set and bit 5 is clear) or (the error code is non-zero and bit 6 is clear). Both masks set after reset keep it low.
- R9: While seeded and no operation is in progress, one word per cycle enters the queue until it holds FIFO_DEPTH words. Nothing enters while unseeded. Status bits 11:8 give the fill count, saturating at 15.
- R10: A read of offset 0x14 returns and removes the oldest queued word. On an empty queue it returns zero and leaves the fill count unchanged.
- R11: A count of words served, cleared by every successful seed, saturates at RESEED_WORDS. When the count has reached RESEED_WORDS and auto reseeding is enabled, the block starts a seed generation on its own as soon as it is seeded and idle. With auto reseeding disabled, no seed starts.
- R12: After a failed seed, clearing the error and issuing the seed command again with a passing outcome seeds the generator, and filling begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| selftest_fail_in | input | 1 | Injected self-test outcome, high means fail |
| stat_fail_in | input | 1 | Injected statistical-test outcome for seeding, high means fail |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 20-word queue, a 5-cycle self-test, an 8-cycle seed and a reseed limit of 6 words. With a 20-word queue the fill count passes 15, so the saturation of the 4-bit level field can be observed, and the depth is not a power of two, which exercises the explicit pointer wrap. The short operation lengths make the exact completion edges cheap to check. The limit of 6 allows the automatic reseed, with the option both disabled and enabled, to be triggered with a handful of reads rather than about a million.

// File: rtl/rng_regblock_pkg.sv
// Shared constants for the random number generator register block.
// Assumes a byte-addressed 32-bit register bus with word-aligned offsets.
package rng_regblock_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    // Register offsets
    localparam logic [BUS_AW-1:0] OFS_IDENT  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_CMD    = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_ERRC   = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_POP    = 8'h14;

    // Command bit positions
    localparam int CMD_SELFTEST = 0;
    localparam int CMD_SEED     = 1;
    localparam int CMD_CLRINT   = 4;
    localparam int CMD_CLRERR   = 5;

    // Control bit positions
    localparam int CTRL_AUTO  = 4;
    localparam int CTRL_MDONE = 5;
    localparam int CTRL_MERR  = 6;

    // Status bit positions
    localparam int STAT_STDONE   = 4;
    localparam int STAT_SEEDDONE = 5;
    localparam int STAT_LVL_LO   = 8;
    localparam int STAT_ERR      = 16;

    // Error codes
    localparam logic [BUS_DW-1:0] ERR_NONE     = 32'h0;
    localparam logic [BUS_DW-1:0] ERR_SELFTEST = 32'h1;
    localparam logic [BUS_DW-1:0] ERR_STAT     = 32'h8;

    typedef enum logic [1:0] {
        OP_IDLE     = 2'd0,
        OP_SELFTEST = 2'd1,
        OP_SEED     = 2'd2
    } op_state_e;

endpackage

// File: rtl/rng_op_engine.sv
// Operation sequencer: runs self-test and seed generation for a fixed
// number of cycles, holds the done flags, the error code and the seeded
// state, and forms the interrupt. Assumes ST_CYCLES and SEED_CYCLES >= 1.
module rng_op_engine
    import rng_regblock_pkg::*;
#(
    parameter int ST_CYCLES   = 64,
    parameter int SEED_CYCLES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_selftest,
    input  logic              start_seed,
    input  logic              auto_reseed_req,
    input  logic              clr_int,
    input  logic              clr_err,
    input  logic              selftest_fail,
    input  logic              stat_fail,
    input  logic              mask_done,
    input  logic              mask_err,
    output logic              busy,
    output logic              st_done,
    output logic              seed_done,
    output logic              seeded,
    output logic              seed_ok,
    output logic [BUS_DW-1:0] err_code,
    output logic              irq
);

    localparam int MAX_CYC = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES;
    localparam int TW      = $clog2(MAX_CYC + 1);

    op_state_e       state;
    logic [TW-1:0]   timer;
    logic            finishing;

    // The running operation completes on this edge
    assign finishing = (state != OP_IDLE) && (timer == '0);
    // A seed completes on this edge with a passing outcome
    assign seed_ok   = (state == OP_SEED) && (timer == '0) && !stat_fail;
    assign busy      = (state != OP_IDLE);

    // Sequencing, flags and error code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= OP_IDLE;
            timer     <= '0;
            st_done   <= 1'b0;
            seed_done <= 1'b0;
            seeded    <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            if (clr_err) begin
                err_code  <= ERR_NONE;
                st_done   <= 1'b0;
                seed_done <= 1'b0;
            end else if (clr_int && (err_code == ERR_NONE)) begin
                st_done   <= 1'b0;
                seed_done <= 1'b0;
            end

            unique case (state)
                OP_IDLE: begin
                    if (start_selftest) begin
                        state <= OP_SELFTEST;
                        timer <= TW'(ST_CYCLES - 1);
                    end else if (start_seed || (auto_reseed_req && seeded)) begin
                        state <= OP_SEED;
                        timer <= TW'(SEED_CYCLES - 1);
                    end
                end
                OP_SELFTEST: begin
                    if (finishing) begin
                        state   <= OP_IDLE;
                        st_done <= 1'b1;
                        if (selftest_fail) err_code <= ERR_SELFTEST;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                OP_SEED: begin
                    if (finishing) begin
                        state     <= OP_IDLE;
                        seed_done <= 1'b1;
                        if (stat_fail) begin
                            err_code <= ERR_STAT;
                            seeded   <= 1'b0;
                        end else begin
                            seeded   <= 1'b1;
                        end
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
                default: state <= OP_IDLE;
            endcase
        end
    end

    // Interrupt: masked done flags or masked error
    assign irq = ((st_done || seed_done) && !mask_done) ||
                 ((err_code != ERR_NONE) && !mask_err);

endmodule

// File: rtl/rng_word_src.sv
// Stand-in word source: a 32-bit Galois LFSR stirred on each successful
// seed, plus the served-word counter that requests automatic reseeding.
// Assumes RESEED_WORDS >= 1; it is not an entropy source.
module rng_word_src
    import rng_regblock_pkg::*;
#(
    parameter int RESEED_WORDS = 1 << 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load_seed,
    input  logic              served,
    input  logic              auto_en,
    output logic [BUS_DW-1:0] word,
    output logic              reseed_req
);

    localparam int                CW      = $clog2(RESEED_WORDS + 1);
    localparam logic [BUS_DW-1:0] TAPS    = 32'hA300_0000;
    localparam logic [BUS_DW-1:0] INIT    = 32'h1D87_2B41;

    logic [BUS_DW-1:0] lfsr;
    logic [BUS_DW-1:0] mix;
    logic [15:0]       stir;
    logic [CW-1:0]     served_cnt;

    // Seed value taken from the current state and a free-running stir count
    assign mix = lfsr ^ {stir, ~stir};

    // Free-running stir counter
    always_ff @(posedge clk) begin
        if (!rst_n) stir <= '0;
        else        stir <= stir + 1'b1;
    end

    // LFSR state: reload on seed, step on each word taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= INIT;
        end else if (load_seed) begin
            lfsr <= (mix == '0) ? INIT : mix;
        end else if (advance) begin
            lfsr <= {1'b0, lfsr[BUS_DW-1:1]} ^ (lfsr[0] ? TAPS : '0);
        end
    end

    // Served-word count, saturating at the reseed limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_cnt <= '0;
        end else if (load_seed) begin
            served_cnt <= '0;
        end else if (served && (served_cnt < CW'(RESEED_WORDS))) begin
            served_cnt <= served_cnt + 1'b1;
        end
    end

    assign word       = lfsr;
    assign reseed_req = auto_en && (served_cnt == CW'(RESEED_WORDS));

endmodule

// File: rtl/rng_word_fifo.sv
// Output word queue. The caller pushes only when not full and pops only
// when not empty. Assumes DEPTH >= 2; non-power-of-two depths wrap explicitly.
module rng_word_fifo
    import rng_regblock_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [BUS_DW-1:0]          wdata,
    output logic [BUS_DW-1:0]          rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [BUS_DW-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/rng_regblock.sv
// Register block of the random number generator: decodes the bus,
// holds the control word, composes status and read data, and wires the
// sequencer, word source and queue. Reads are combinational in the
// strobe cycle; a read of the pop port removes a word on that edge.
module rng_regblock
    import rng_regblock_pkg::*;
#(
    parameter int         FIFO_DEPTH   = 16,
    parameter int         ST_CYCLES    = 64,
    parameter int         SEED_CYCLES  = 512,
    parameter int         RESEED_WORDS = 1 << 20,
    parameter logic [3:0] HW_TYPE      = 4'h2,
    parameter logic [7:0] REV_MAJOR    = 8'h01,
    parameter logic [7:0] REV_MINOR    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              selftest_fail_in,
    input  logic              stat_fail_in,
    output logic              irq_out
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              wr_cmd, wr_ctrl;
    logic [2:0]        ctrl_q;          // {mask err, mask done, auto}
    logic              busy, st_done, seed_done, seeded, seed_ok;
    logic [BUS_DW-1:0] err_code;
    logic [BUS_DW-1:0] src_word, head_word;
    logic              reseed_req;
    logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [CNT_W-1:0]  fifo_count;
    logic [3:0]        level;
    logic [BUS_DW-1:0] status_word, ident_word;
    logic              unused_wbits;

    assign wr_cmd  = bus_wr_en && (bus_addr == OFS_CMD);
    assign wr_ctrl = bus_wr_en && (bus_addr == OFS_CTRL);
    assign unused_wbits = ^{bus_wdata[BUS_DW-1:7], bus_wdata[3:2]};

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= 3'b110;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_MERR:CTRL_AUTO];
    end

    rng_op_engine #(
        .ST_CYCLES   (ST_CYCLES),
        .SEED_CYCLES (SEED_CYCLES)
    ) u_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_selftest  (wr_cmd && bus_wdata[CMD_SELFTEST]),
        .start_seed      (wr_cmd && bus_wdata[CMD_SEED]),
        .auto_reseed_req (reseed_req),
        .clr_int         (wr_cmd && bus_wdata[CMD_CLRINT]),
        .clr_err         (wr_cmd && bus_wdata[CMD_CLRERR]),
        .selftest_fail   (selftest_fail_in),
        .stat_fail       (stat_fail_in),
        .mask_done       (ctrl_q[1]),
        .mask_err        (ctrl_q[2]),
        .busy            (busy),
        .st_done         (st_done),
        .seed_done       (seed_done),
        .seeded          (seeded),
        .seed_ok         (seed_ok),
        .err_code        (err_code),
        .irq             (irq_out)
    );

    assign fifo_push = seeded && !busy && !fifo_full;
    assign fifo_pop  = bus_rd_en && (bus_addr == OFS_POP) && !fifo_empty;

    rng_word_src #(
        .RESEED_WORDS (RESEED_WORDS)
    ) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (fifo_push),
        .load_seed  (seed_ok),
        .served     (fifo_pop),
        .auto_en    (ctrl_q[0]),
        .word       (src_word),
        .reseed_req (reseed_req)
    );

    rng_word_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .wdata (src_word),
        .rdata (head_word),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Fill level field, saturating at 15
    generate
        if (CNT_W > 4) begin : g_lvl_sat
            assign level = (fifo_count > CNT_W'(15)) ? 4'hF : fifo_count[3:0];
        end else if (CNT_W == 4) begin : g_lvl_eq
            assign level = fifo_count;
        end else begin : g_lvl_ext
            assign level = {{(4 - CNT_W){1'b0}}, fifo_count};
        end
    endgenerate

    // Status word composition
    always_comb begin
        status_word                = '0;
        status_word[STAT_STDONE]   = st_done;
        status_word[STAT_SEEDDONE] = seed_done;
        status_word[STAT_LVL_LO+:4] = level;
        status_word[STAT_ERR]      = (err_code != ERR_NONE);
    end

    assign ident_word = {HW_TYPE, 12'h000, REV_MAJOR, REV_MINOR};

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            unique case (bus_addr)
                OFS_IDENT:  bus_rdata = ident_word;
                OFS_CMD:    bus_rdata = '0;
                OFS_CTRL:   bus_rdata = {25'b0, ctrl_q, 4'b0};
                OFS_STATUS: bus_rdata = status_word;
                OFS_ERRC:   bus_rdata = err_code;
                OFS_POP:    bus_rdata = fifo_empty ? '0 : head_word;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rng_regblock_chk.sv
// Property checker for rng_regblock, attached by the bind at the end.
// Observes bus ports and internal state; drives nothing.
module rng_regblock_chk
    import rng_regblock_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              bus_rd_en,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic              irq_out,
    input logic [2:0]        ctrl_q,
    input logic              busy,
    input logic              st_done,
    input logic              seed_done,
    input logic              seeded,
    input logic [BUS_DW-1:0] err_code,
    input logic [CW-1:0]     fifo_count
);

    // R2
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFS_CMD) |-> (bus_rdata == '0));

    // R8
    masked_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1] && ctrl_q[2]) |-> !irq_out);

    // R10
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFS_POP && fifo_count == '0) |-> (bus_rdata == '0));

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R9
    no_fill_unseeded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seeded |=> (fifo_count <= $past(fifo_count)));

    // R6
    clr_int_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFS_CMD && bus_wdata[CMD_CLRINT] &&
         !bus_wdata[CMD_CLRERR] && err_code != '0 && st_done) |=> st_done);

    // R6
    clr_err_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFS_CMD && bus_wdata[CMD_CLRERR] && !busy)
        |=> (err_code == '0 && !st_done && !seed_done));

    // R7
    status_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFS_STATUS) |-> (bus_rdata[STAT_ERR] == (err_code != '0)));

endmodule

bind rng_regblock rng_regblock_chk #(
    .DEPTH (FIFO_DEPTH),
    .CW    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .bus_rd_en  (bus_rd_en),
    .bus_rdata  (bus_rdata),
    .irq_out    (irq_out),
    .ctrl_q     (ctrl_q),
    .busy       (busy),
    .st_done    (st_done),
    .seed_done  (seed_done),
    .seeded     (seeded),
    .err_code   (err_code),
    .fifo_count (fifo_count)
);

// File: tb/rng_regblock_bench.sv
module rng_regblock_bench;

    localparam int DEPTH = 20;
    localparam int STC   = 5;
    localparam int SDC   = 8;
    localparam int RSW   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        selftest_fail_in = 1'b0;
    logic        stat_fail_in = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rng_regblock #(
        .FIFO_DEPTH   (DEPTH),
        .ST_CYCLES    (STC),
        .SEED_CYCLES  (SDC),
        .RESEED_WORDS (RSW),
        .HW_TYPE      (4'h2),
        .REV_MAJOR    (8'h03),
        .REV_MINOR    (8'h21)
    ) u_rng_regblock (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .bus_wr_en        (bus_wr_en),
        .bus_wdata        (bus_wdata),
        .bus_rd_en        (bus_rd_en),
        .bus_rdata        (bus_rdata),
        .selftest_fail_in (selftest_fail_in),
        .stat_fail_in     (stat_fail_in),
        .irq_out          (irq_out)
    );

    // Vector: {is_write, addr, data, expected read}
    localparam int NV = 13;
    localparam logic [72:0] VECS [NV] = '{
        {1'b0, 8'h00, 32'h0, 32'h2000_0321},  // R1 identity
        {1'b0, 8'h04, 32'h0, 32'h0},          // R2 command reads zero
        {1'b0, 8'h08, 32'h0, 32'h0000_0060},  // R3 reset control
        {1'b0, 8'h0C, 32'h0, 32'h0},          // R7 reset status
        {1'b0, 8'h10, 32'h0, 32'h0},          // R7 reset error
        {1'b0, 8'h14, 32'h0, 32'h0},          // R10 empty pop returns zero
        {1'b0, 8'h0C, 32'h0, 32'h0},          // R10 level unchanged
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h08, 32'h0, 32'h0000_0070},  // R3 only bits 6:4 stored
        {1'b1, 8'h04, 32'hFFFF_FFCC, 32'h0},
        {1'b0, 8'h0C, 32'h0, 32'h0},          // R2 no action bits, nothing starts
        {1'b1, 8'h08, 32'h0000_0060, 32'h0},
        {1'b0, 8'h08, 32'h0, 32'h0000_0060}   // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        logic [31:0] v, w1, w2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        check("R8 irq low after reset", {31'b0, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][72]) wr(VECS[i][71:64], VECS[i][63:32]);
            else begin
                rd(VECS[i][71:64], v);
                check($sformatf("table entry %0d", i), v, VECS[i][31:0]);
            end
        end

        // Self-test pass, bit0 beats bit1, exact completion edge
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h3);
        idle(STC - 1);
        rd(8'h0C, v); check("R4 self-test not done early", v, 32'h0);
        rd(8'h0C, v); check("R4 R2 self-test done, no seed", v, 32'h10);
        check("R8 irq on done", {31'b0, irq_out}, 32'h1);
        wr(8'h08, 32'h20);
        check("R8 done masked", {31'b0, irq_out}, 32'h0);
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h10);
        rd(8'h0C, v); check("R6 clear-int without error", v, 32'h0);
        check("R8 irq after clear", {31'b0, irq_out}, 32'h0);

        // Start while busy is ignored
        wr(8'h04, 32'h1);
        wr(8'h04, 32'h2);
        idle(STC + 3);
        rd(8'h0C, v); check("R2 seed start while busy ignored", v, 32'h10);
        wr(8'h04, 32'h10);

        // Self-test failure, masks and asymmetric clears
        selftest_fail_in = 1'b1;
        wr(8'h04, 32'h1);
        idle(STC + 2);
        selftest_fail_in = 1'b0;
        rd(8'h10, v); check("R4 self-test error code", v, 32'h1);
        rd(8'h0C, v); check("R7 status error flag", v, 32'h0001_0010);
        wr(8'h08, 32'h40);
        check("R8 error masked, done unmasked", {31'b0, irq_out}, 32'h1);
        wr(8'h08, 32'h60);
        check("R8 both masked", {31'b0, irq_out}, 32'h0);
        wr(8'h08, 32'h20);
        check("R8 error unmasked", {31'b0, irq_out}, 32'h1);
        wr(8'h04, 32'h10);
        rd(8'h0C, v); check("R6 clear-int blocked by error", v, 32'h0001_0010);
        wr(8'h04, 32'h20);
        rd(8'h0C, v); check("R6 clear-err wipes flags", v, 32'h0);
        rd(8'h10, v); check("R6 clear-err wipes code", v, 32'h0);
        check("R8 irq after clear-err", {31'b0, irq_out}, 32'h0);

        // Seed with statistical failure
        stat_fail_in = 1'b1;
        wr(8'h04, 32'h2);
        idle(SDC - 1);
        rd(8'h0C, v); check("R5 seed not done early", v, 32'h0);
        rd(8'h0C, v); check("R5 seed done with error", v, 32'h0001_0020);
        rd(8'h10, v); check("R5 statistical error code", v, 32'h8);
        stat_fail_in = 1'b0;
        idle(5);
        rd(8'h0C, v); check("R9 no fill while unseeded", v, 32'h0001_0020);
        rd(8'h14, v); check("R10 pop empty after failed seed", v, 32'h0);

        // Retry after clearing the error
        wr(8'h04, 32'h20);
        wr(8'h04, 32'h2);
        idle(SDC + 3);
        rd(8'h0C, v); check("R12 R9 retry seeds, three words queued", v, 32'h0000_0320);
        rd(8'h10, v); check("R12 no error after retry", v, 32'h0);

        // Fill to the top and pop
        idle(40);
        rd(8'h0C, v); check("R9 level saturates at 15", v, 32'h0000_0F20);
        rd(8'h14, w1);
        rd(8'h14, w2);
        check("R10 popped word nonzero", {31'b0, (w1 != 32'h0)}, 32'h1);
        check("R10 successive words differ", {31'b0, (w1 != w2)}, 32'h1);

        // Auto reseed disabled, then enabled
        wr(8'h04, 32'h10);
        for (int k = 0; k < RSW + 1; k++) rd(8'h14, v);
        idle(SDC + 4);
        rd(8'h0C, v); check("R11 no reseed while disabled", v, 32'h0000_0F00);
        wr(8'h08, 32'h70);
        idle(SDC + 3);
        rd(8'h0C, v); check("R11 reseed on enable after limit", v, 32'h0000_0F20);
        wr(8'h04, 32'h10);
        for (int k = 0; k < RSW - 1; k++) rd(8'h14, v);
        idle(SDC + 4);
        rd(8'h0C, v); check("R11 no reseed below limit", v, 32'h0000_0F00);
        rd(8'h14, v);
        idle(SDC + 3);
        rd(8'h0C, v); check("R11 reseed at limit", v, 32'h0000_0F20);

        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            summary();
        end
    end

endmodule